// File: doc/BRIEF.md
# Private Interrupt Register Bank

This block holds the per-processor configuration and state of 32 private interrupts: sixteen software-generated interrupts (numbers 0 to 15) and sixteen peripheral interrupts (numbers 16 to 31). A register-access master reaches the bank through a single-cycle access port. Each access carries a secure or non-secure attribute. A global security-disable input decides whether that attribute narrows what the access can see.

The bank drives its enable, pending, active, group, trigger and priority vectors straight to a downstream priority resolver. The sixteen peripheral input lines come into the bank itself. A level-triggered line shows up in the pending view while it is high. A rising edge on an edge-triggered line sets the pending latch.

When security is enabled, a non-secure access touches only the Group-1 interrupts. It sees their priorities through a halved view: the value is shifted, and the top bit is forced to 1 on a write.

Top module: `ppi_regfile`

## Requirements
- R1: After reset, every bitmap, the wake bit and all 32 priorities are zero. The edge vector reads 0x0000FFFF, with the software-generated interrupts always edge-triggered and the peripheral interrupts level-triggered. rd_valid and err_pulse are low.
- R2: Enable, pending and active each have two word addresses: set (0x10, 0x18, 0x20) and clear (0x14, 0x1C, 0x24). Writing 1s to the set address ORs them into the register, and writing 1s to the clear address removes them. Both addresses of a pair read the current value.
- R3: A non-secure access while security is enabled (sec_disable=0) has every bitmap read, set, clear and trigger-config access ANDed with the group register (0x04). Group-0 bits read as zero and ignore writes. In every other case the mask is all ones.
- R4: The group register (0x04) reads as zero and ignores writes for a non-secure access while security is enabled.
- R5: The group-modifier (0x08) and non-secure-access (0x0C) registers read as zero and ignore writes when sec_disable=1 or the access is non-secure.
- R6: Priorities occupy the window 0x40–0x5F, one byte per interrupt, where interrupt n lives at 0x40+n. A word access covers four interrupts, with the lowest number in bits 7:0. A byte access uses bits 7:0 of the data.
- R7: A non-secure access with security enabled reads a Group-1 priority p as (p<<1)&0xFF and writes v as 0x80|(v>>1). Group-0 priority fields read as 0 and ignore writes.
- R8: Pending reads as the pending latch ORed with the input level of every level-triggered interrupt (line k is interrupt 16+k). A 0-to-1 change on an edge-triggered line sets the latch.
- R9: Trigger config 0x28 covers interrupts 0–15 and 0x2C covers interrupts 16–31. Each has its edge bit at odd position 2j+1 and zeros elsewhere. 0x28 ignores writes. A write to 0x2C takes its odd bits as the new edge bits, under the R3 mask.
- R10: In the wake register (0x00), only bit 0 (sleep request) is writable. Bit 1 (asleep) always reads equal to bit 0.
- R11: Some accesses are invalid: an undefined offset, a size other than byte (0) or word (2), a byte access outside the priority window, or a word access with a misaligned address. An invalid access reads zero, changes nothing and raises err_pulse for one cycle in the cycle after the access.
- R12: When an edge-triggered line rises in the same cycle as a clear-pending write to that interrupt, the pending bit ends up set.
- R13: Read data and rd_valid appear in the cycle after the read access. rd_valid is low after a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_disable | input | 1 | 1 = single security state, all accesses unrestricted |
| acc_valid | input | 1 | Access strobe, one cycle per access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_secure | input | 1 | 1 = secure access |
| acc_size | input | 2 | 0 = byte, 2 = word, others unsupported |
| acc_addr | input | ADDR_W | Byte offset within the bank |
| acc_wdata | input | 32 | Write data |
| ppi_level | input | 16 | Peripheral interrupt lines, bit k is interrupt 16+k |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| err_pulse | output | 1 | One-cycle pulse for an invalid access |
| enable_vec | output | 32 | Enable bits |
| pending_vec | output | 32 | Pending view (latch OR level of level-triggered lines) |
| active_vec | output | 32 | Active bits |
| group_vec | output | 32 | Group bits |
| edge_vec | output | 32 | 1 = edge-triggered |
| prio_flat | output | 256 | Priorities, interrupt n at bits 8n+7:8n |

## Verification
Two functions can fall in the same cycle: the line-edge latch and a register write to the pending clear address. To provoke this, a peripheral line is driven from low to high on the same clock edge as the clear write that names that interrupt. The pending output and a later read must both show the bit set.

The random phase also changes line levels on cycles that carry pending set and clear writes. Every outcome is compared against a bench model that applies the write first and the edge latch after it.

// File: rtl/ppi_pkg.sv
package ppi_pkg;
    localparam int NIRQ    = 32;
    localparam int NSGI    = 16;
    localparam int NPPI    = NIRQ - NSGI;
    localparam int PRIO_W  = 8;
    localparam int DW      = 32;
    localparam int IDX_W   = $clog2(NIRQ);

    localparam logic [7:0] OFF_WAKE  = 8'h00;
    localparam logic [7:0] OFF_GRP   = 8'h04;
    localparam logic [7:0] OFF_GMOD  = 8'h08;
    localparam logic [7:0] OFF_NSAC  = 8'h0C;
    localparam logic [7:0] OFF_ENS   = 8'h10;
    localparam logic [7:0] OFF_ENC   = 8'h14;
    localparam logic [7:0] OFF_PDS   = 8'h18;
    localparam logic [7:0] OFF_PDC   = 8'h1C;
    localparam logic [7:0] OFF_ACS   = 8'h20;
    localparam logic [7:0] OFF_ACC   = 8'h24;
    localparam logic [7:0] OFF_CFG0  = 8'h28;
    localparam logic [7:0] OFF_CFG1  = 8'h2C;
    localparam logic [7:0] PRIO_BASE = 8'h40;
    localparam logic [7:0] PRIO_SPAN = 8'h20;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_WORD = 2'd2;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_WAKE, SEL_GRP, SEL_GMOD, SEL_NSAC,
        SEL_ENS, SEL_ENC, SEL_PDS, SEL_PDC, SEL_ACS, SEL_ACC,
        SEL_CFG0, SEL_CFG1, SEL_PRIO
    } sel_e;

    function automatic logic [DW-1:0] spread_odd(input logic [NSGI-1:0] v);
        logic [DW-1:0] r;
        r = '0;
        for (int j = 0; j < NSGI; j++) r[2*j+1] = v[j];
        return r;
    endfunction

    function automatic logic [NSGI-1:0] pick_odd(input logic [DW-1:0] w);
        logic [NSGI-1:0] r;
        for (int j = 0; j < NSGI; j++) r[j] = w[2*j+1];
        return r;
    endfunction
endpackage

// File: rtl/ppi_access_gate.sv
module ppi_access_gate
    import ppi_pkg::*;
(
    input  logic            sec_disable,
    input  logic            acc_secure,
    input  logic [NIRQ-1:0] grp,
    output logic [NIRQ-1:0] bit_mask,
    output logic            ns_view,
    output logic            grp_ok,
    output logic            bank_ok
);
    always_comb begin
        ns_view  = !sec_disable && !acc_secure;
        bit_mask = ns_view ? grp : '1;
        grp_ok   = !ns_view;
        bank_ok  = !sec_disable && acc_secure;
    end
endmodule

// File: rtl/ppi_prio_bank.sv
module ppi_prio_bank
    import ppi_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_req,
    input  logic                   byte_mode,
    input  logic [IDX_W-1:0]       idx,
    input  logic [DW-1:0]          wdata,
    input  logic                   ns_view,
    input  logic [NIRQ-1:0]        grp,
    output logic [DW-1:0]          rd_view,
    output logic [NIRQ*PRIO_W-1:0] prio_flat
);
    localparam int LANES = DW / PRIO_W;

    logic [PRIO_W-1:0] prio_q [NIRQ];
    logic [PRIO_W-1:0] prio_d [NIRQ];
    logic [PRIO_W-1:0] lane_val [NIRQ];
    logic [PRIO_W-1:0] view [NIRQ];
    logic [NIRQ-1:0]   lane_addr;
    logic [NIRQ-1:0]   lane_hit;

    for (genvar i = 0; i < NIRQ; i++) begin : g_lane
        logic [PRIO_W-1:0] raw;
        assign raw          = byte_mode ? wdata[PRIO_W-1:0] : wdata[PRIO_W*(i%LANES) +: PRIO_W];
        assign lane_addr[i] = byte_mode ? (idx == IDX_W'(i))
                                        : (idx[IDX_W-1:2] == (IDX_W-2)'(i/LANES));
        assign lane_hit[i]  = wr_req && lane_addr[i] && (!ns_view || grp[i]);
        assign lane_val[i]  = ns_view ? {1'b1, raw[PRIO_W-1:1]} : raw;
        assign view[i]      = ns_view ? (grp[i] ? {prio_q[i][PRIO_W-2:0], 1'b0} : '0)
                                      : prio_q[i];
        assign prio_flat[PRIO_W*i +: PRIO_W] = prio_q[i];

        // R7
        ns_group0_wi_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_req && ns_view && !grp[i] && lane_addr[i]) |=> $stable(prio_q[i]));
        // R7
        ns_top_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_req && ns_view && grp[i] && lane_addr[i]) |=> prio_q[i][PRIO_W-1]);
    end

    always_comb begin
        for (int i = 0; i < NIRQ; i++) begin
            prio_d[i] = lane_hit[i] ? lane_val[i] : prio_q[i];
        end
    end

    always_comb begin
        if (byte_mode) begin
            rd_view = {{(DW-PRIO_W){1'b0}}, view[idx]};
        end else begin
            for (int k = 0; k < LANES; k++) begin
                rd_view[PRIO_W*k +: PRIO_W] = view[{idx[IDX_W-1:2], 2'(k)}];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NIRQ; i++) prio_q[i] <= '0;
        end else begin
            for (int i = 0; i < NIRQ; i++) prio_q[i] <= prio_d[i];
        end
    end
endmodule

// File: rtl/ppi_regfile.sv
module ppi_regfile
    import ppi_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sec_disable,
    input  logic                   acc_valid,
    input  logic                   acc_write,
    input  logic                   acc_secure,
    input  logic [1:0]             acc_size,
    input  logic [ADDR_W-1:0]      acc_addr,
    input  logic [DW-1:0]          acc_wdata,
    input  logic [NPPI-1:0]        ppi_level,
    output logic                   rd_valid,
    output logic [DW-1:0]          rd_data,
    output logic                   err_pulse,
    output logic [NIRQ-1:0]        enable_vec,
    output logic [NIRQ-1:0]        pending_vec,
    output logic [NIRQ-1:0]        active_vec,
    output logic [NIRQ-1:0]        group_vec,
    output logic [NIRQ-1:0]        edge_vec,
    output logic [NIRQ*PRIO_W-1:0] prio_flat
);
    typedef struct packed {
        logic [NIRQ-1:0] en;
        logic [NIRQ-1:0] pend;
        logic [NIRQ-1:0] act;
        logic [NIRQ-1:0] grp;
        logic [NIRQ-1:0] gmod;
        logic [NIRQ-1:0] nsac;
        logic [NPPI-1:0] edge_hi;
        logic [NPPI-1:0] line;
        logic            sleep;
        logic            rd_valid;
        logic [DW-1:0]   rd_data;
        logic            err;
    } state_t;

    state_t st_q, st_d;
    sel_e   sel;

    logic [NIRQ-1:0] bit_mask;
    logic            ns_view, grp_ok, bank_ok;
    logic [DW-1:0]   prio_rd;
    logic [NIRQ-1:0] edge_all, level_all, pend_view;

    ppi_access_gate u_gate (
        .sec_disable (sec_disable),
        .acc_secure  (acc_secure),
        .grp         (st_q.grp),
        .bit_mask    (bit_mask),
        .ns_view     (ns_view),
        .grp_ok      (grp_ok),
        .bank_ok     (bank_ok)
    );

    ppi_prio_bank u_prio (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_req    (acc_valid && acc_write && (sel == SEL_PRIO)),
        .byte_mode (acc_size == SZ_BYTE),
        .idx       (acc_addr[IDX_W-1:0]),
        .wdata     (acc_wdata),
        .ns_view   (ns_view),
        .grp       (st_q.grp),
        .rd_view   (prio_rd),
        .prio_flat (prio_flat)
    );

    // address and size decode
    always_comb begin
        logic in_prio;
        in_prio = (acc_addr >= ADDR_W'(PRIO_BASE)) && (acc_addr < ADDR_W'(PRIO_BASE + PRIO_SPAN));
        sel = SEL_NONE;
        if (acc_size == SZ_WORD && acc_addr[1:0] == 2'b00) begin
            if (in_prio) sel = SEL_PRIO;
            else begin
                case (acc_addr)
                    ADDR_W'(OFF_WAKE): sel = SEL_WAKE;
                    ADDR_W'(OFF_GRP):  sel = SEL_GRP;
                    ADDR_W'(OFF_GMOD): sel = SEL_GMOD;
                    ADDR_W'(OFF_NSAC): sel = SEL_NSAC;
                    ADDR_W'(OFF_ENS):  sel = SEL_ENS;
                    ADDR_W'(OFF_ENC):  sel = SEL_ENC;
                    ADDR_W'(OFF_PDS):  sel = SEL_PDS;
                    ADDR_W'(OFF_PDC):  sel = SEL_PDC;
                    ADDR_W'(OFF_ACS):  sel = SEL_ACS;
                    ADDR_W'(OFF_ACC):  sel = SEL_ACC;
                    ADDR_W'(OFF_CFG0): sel = SEL_CFG0;
                    ADDR_W'(OFF_CFG1): sel = SEL_CFG1;
                    default:           sel = SEL_NONE;
                endcase
            end
        end else if (acc_size == SZ_BYTE && in_prio) begin
            sel = SEL_PRIO;
        end
    end

    assign edge_all  = {st_q.edge_hi, {NSGI{1'b1}}};
    assign level_all = {ppi_level, {NSGI{1'b0}}};
    assign pend_view = st_q.pend | (level_all & ~edge_all);

    always_comb begin
        logic [DW-1:0]   wm;
        logic [NPPI-1:0] rise;
        st_d          = st_q;
        st_d.rd_valid = acc_valid && !acc_write;
        st_d.rd_data  = '0;
        st_d.err      = acc_valid && (sel == SEL_NONE);
        wm            = acc_wdata & bit_mask;

        if (acc_valid && !acc_write) begin
            case (sel)
                SEL_WAKE: st_d.rd_data = {{(DW-2){1'b0}}, st_q.sleep, st_q.sleep};
                SEL_GRP:  st_d.rd_data = grp_ok  ? st_q.grp  : '0;
                SEL_GMOD: st_d.rd_data = bank_ok ? st_q.gmod : '0;
                SEL_NSAC: st_d.rd_data = bank_ok ? st_q.nsac : '0;
                SEL_ENS, SEL_ENC: st_d.rd_data = st_q.en & bit_mask;
                SEL_PDS, SEL_PDC: st_d.rd_data = pend_view & bit_mask;
                SEL_ACS, SEL_ACC: st_d.rd_data = st_q.act & bit_mask;
                SEL_CFG0: st_d.rd_data = spread_odd(edge_all[NSGI-1:0] & bit_mask[NSGI-1:0]);
                SEL_CFG1: st_d.rd_data = spread_odd(edge_all[NIRQ-1:NSGI] & bit_mask[NIRQ-1:NSGI]);
                SEL_PRIO: st_d.rd_data = prio_rd;
                default:  st_d.rd_data = '0;
            endcase
        end

        if (acc_valid && acc_write) begin
            case (sel)
                SEL_WAKE: st_d.sleep = acc_wdata[0];
                SEL_GRP:  if (grp_ok)  st_d.grp  = acc_wdata;
                SEL_GMOD: if (bank_ok) st_d.gmod = acc_wdata;
                SEL_NSAC: if (bank_ok) st_d.nsac = acc_wdata;
                SEL_ENS:  st_d.en   = st_q.en   | wm;
                SEL_ENC:  st_d.en   = st_q.en   & ~wm;
                SEL_PDS:  st_d.pend = st_q.pend | wm;
                SEL_PDC:  st_d.pend = st_q.pend & ~wm;
                SEL_ACS:  st_d.act  = st_q.act  | wm;
                SEL_ACC:  st_d.act  = st_q.act  & ~wm;
                SEL_CFG1: st_d.edge_hi = (st_q.edge_hi & ~bit_mask[NIRQ-1:NSGI])
                                       | (pick_odd(acc_wdata) & bit_mask[NIRQ-1:NSGI]);
                default: ;
            endcase
        end

        // line edge latch applied after any register write (R12)
        rise      = ppi_level & ~st_q.line & st_q.edge_hi;
        st_d.pend = st_d.pend | {rise, {NSGI{1'b0}}};
        st_d.line = ppi_level;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_valid    = st_q.rd_valid;
    assign rd_data     = st_q.rd_data;
    assign err_pulse   = st_q.err;
    assign enable_vec  = st_q.en;
    assign pending_vec = pend_view;
    assign active_vec  = st_q.act;
    assign group_vec   = st_q.grp;
    assign edge_vec    = edge_all;

    // R2
    set_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && acc_secure && acc_size == SZ_WORD && acc_addr == ADDR_W'(OFF_ENS))
        |=> ((enable_vec & $past(acc_wdata)) == $past(acc_wdata)));
    // R2
    clr_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && acc_secure && acc_size == SZ_WORD && acc_addr == ADDR_W'(OFF_ACC))
        |=> ((active_vec & $past(acc_wdata)) == '0));
    // R4
    ns_group_wi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && !acc_secure && !sec_disable && acc_addr == ADDR_W'(OFF_GRP))
        |=> (group_vec == $past(group_vec)));
    // R11
    bad_size_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && (acc_size == 2'd1 || acc_size == 2'd3)) |=> (err_pulse && rd_data == '0));
    // R13
    rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write) |=> rd_valid);
endmodule

// File: tb/ppi_regfile_tb_top.sv
module ppi_regfile_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sec_disable = 1'b0;
    logic         acc_valid = 1'b0, acc_write = 1'b0, acc_secure = 1'b0;
    logic [1:0]   acc_size = 2'd0;
    logic [11:0]  acc_addr = '0;
    logic [31:0]  acc_wdata = '0;
    logic [15:0]  ppi_level = '0;
    logic         rd_valid, err_pulse;
    logic [31:0]  rd_data, enable_vec, pending_vec, active_vec, group_vec, edge_vec;
    logic [255:0] prio_flat;

    int n_chk = 0, n_bad = 0;

    logic [31:0] m_en, m_pend, m_act, m_grp, m_gmod, m_nsac;
    logic [15:0] m_edge_hi, m_line;
    logic        m_sleep;
    logic [7:0]  m_prio [32];

    always #5 clk = ~clk;

    ppi_regfile dut_i (
        .clk(clk), .rst_n(rst_n), .sec_disable(sec_disable),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_secure(acc_secure),
        .acc_size(acc_size), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .ppi_level(ppi_level), .rd_valid(rd_valid), .rd_data(rd_data),
        .err_pulse(err_pulse), .enable_vec(enable_vec), .pending_vec(pending_vec),
        .active_vec(active_vec), .group_vec(group_vec), .edge_vec(edge_vec),
        .prio_flat(prio_flat)
    );

    task automatic check(string req, string what, logic [255:0] act, logic [255:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] spread(input logic [15:0] v);
        logic [31:0] r = '0;
        for (int j = 0; j < 16; j++) r[2*j+1] = v[j];
        return r;
    endfunction

    function automatic logic [7:0] pview(input int i, input bit ns);
        if (!ns) return m_prio[i];
        return m_grp[i] ? {m_prio[i][6:0], 1'b0} : 8'h00;
    endfunction

    function automatic logic [255:0] mflat();
        logic [255:0] f;
        for (int i = 0; i < 32; i++) f[8*i +: 8] = m_prio[i];
        return f;
    endfunction

    task automatic pwrite(input int i, input logic [7:0] v, input bit ns);
        if (!ns) m_prio[i] = v;
        else if (m_grp[i]) m_prio[i] = {1'b1, v[7:1]};
    endtask

    task automatic access(input bit w, input bit sec, input logic [1:0] sz,
                          input logic [11:0] a, input logic [31:0] wd,
                          input logic [15:0] lvl, input string req);
        logic [31:0] m, e32, pe, rd, wm;
        logic [15:0] old_edge;
        bit ns, bank, err, inp;
        ns   = !sec_disable && !sec;
        bank = !sec_disable && sec;
        m    = ns ? m_grp : 32'hFFFF_FFFF;
        e32  = {m_edge_hi, 16'hFFFF};
        pe   = m_pend | ({lvl, 16'h0} & ~e32);
        inp  = (a >= 12'h40) && (a < 12'h60);
        rd = '0; err = 1'b0; wm = wd & m;
        old_edge = m_edge_hi;
        if (sz == 2'd2 && a[1:0] == 2'b00 && !inp) begin
            case (a)
                12'h00: begin rd = {30'b0, m_sleep, m_sleep}; if (w) m_sleep = wd[0]; end
                12'h04: begin rd = ns ? '0 : m_grp;   if (w && !ns) m_grp = wd; end
                12'h08: begin rd = bank ? m_gmod : '0; if (w && bank) m_gmod = wd; end
                12'h0C: begin rd = bank ? m_nsac : '0; if (w && bank) m_nsac = wd; end
                12'h10: begin rd = m_en & m;  if (w) m_en = m_en | wm; end
                12'h14: begin rd = m_en & m;  if (w) m_en = m_en & ~wm; end
                12'h18: begin rd = pe & m;    if (w) m_pend = m_pend | wm; end
                12'h1C: begin rd = pe & m;    if (w) m_pend = m_pend & ~wm; end
                12'h20: begin rd = m_act & m; if (w) m_act = m_act | wm; end
                12'h24: begin rd = m_act & m; if (w) m_act = m_act & ~wm; end
                12'h28: rd = spread(e32[15:0] & m[15:0]);
                12'h2C: begin
                    rd = spread(e32[31:16] & m[31:16]);
                    if (w) for (int j = 0; j < 16; j++)
                        if (m[16+j]) m_edge_hi[j] = wd[2*j+1];
                end
                default: err = 1'b1;
            endcase
        end else if (sz == 2'd2 && a[1:0] == 2'b00 && inp) begin
            int b = int'(a - 12'h40);
            for (int k = 0; k < 4; k++) rd[8*k +: 8] = pview(b + k, ns);
            if (w) for (int k = 0; k < 4; k++) pwrite(b + k, wd[8*k +: 8], ns);
        end else if (sz == 2'd0 && inp) begin
            int b = int'(a - 12'h40);
            rd = {24'h0, pview(b, ns)};
            if (w) pwrite(b, wd[7:0], ns);
        end else err = 1'b1;
        if (err) rd = '0;
        m_pend = m_pend | {lvl & ~m_line & old_edge, 16'h0};
        m_line = lvl;

        acc_valid = 1'b1; acc_write = w; acc_secure = sec; acc_size = sz;
        acc_addr = a; acc_wdata = wd; ppi_level = lvl;
        @(negedge clk);
        acc_valid = 1'b0;
        check(req, "rd_valid (R13)", 256'(rd_valid), 256'(!w));
        check(err ? "R11" : req, "err_pulse", 256'(err_pulse), 256'(err));
        if (!w) check(req, "rd_data", 256'(rd_data), 256'(rd));
        check(req, "state vectors",
              {enable_vec, pending_vec, active_vec, group_vec, edge_vec},
              {m_en, m_pend | ({lvl, 16'h0} & ~{m_edge_hi, 16'hFFFF}), m_act, m_grp,
               m_edge_hi, 16'hFFFF});
        check(req, "prio_flat", prio_flat, mflat());
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
    end

    initial begin
        logic [15:0] lv;
        void'($urandom(32'd1234));
        m_en = '0; m_pend = '0; m_act = '0; m_grp = '0; m_gmod = '0; m_nsac = '0;
        m_edge_hi = '0; m_line = '0; m_sleep = 1'b0;
        for (int i = 0; i < 32; i++) m_prio[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", "reset vectors", {enable_vec, pending_vec, active_vec, group_vec, edge_vec},
              {32'h0, 32'h0, 32'h0, 32'h0, 32'h0000FFFF});
        check("R1", "reset prio", prio_flat, '0);
        check("R1", "reset flags", {rd_valid, err_pulse}, 2'b00);
        access(0, 1, 2'd2, 12'h00, 0, 16'h0, "R1");

        // R2 set / clear, both addresses
        access(1, 1, 2'd2, 12'h10, 32'hF0F0_00FF, 16'h0, "R2");
        access(1, 1, 2'd2, 12'h14, 32'h0000_00F0, 16'h0, "R2");
        access(0, 1, 2'd2, 12'h10, 0, 16'h0, "R2");
        check("R2", "en after set/clear", 256'(rd_data), 256'(32'hF0F0_000F));
        access(1, 1, 2'd2, 12'h20, 32'h0000_FFFF, 16'h0, "R2");
        access(1, 1, 2'd2, 12'h24, 32'h0000_0F0F, 16'h0, "R2");

        // R4 / R3 group masking
        access(1, 1, 2'd2, 12'h04, 32'h0000_FF00, 16'h0, "R4");
        access(0, 0, 2'd2, 12'h04, 0, 16'h0, "R4");
        check("R4", "ns group read", 256'(rd_data), 256'(0));
        access(1, 0, 2'd2, 12'h04, 32'hFFFF_FFFF, 16'h0, "R4");
        check("R4", "ns group write ignored", 256'(group_vec), 256'(32'h0000_FF00));
        access(1, 0, 2'd2, 12'h10, 32'hFFFF_FFFF, 16'h0, "R3");
        check("R3", "ns enable set masked", 256'(enable_vec), 256'(32'hF0F0_FF0F));
        access(0, 0, 2'd2, 12'h14, 0, 16'h0, "R3");
        check("R3", "ns enable read masked", 256'(rd_data), 256'(32'h0000_FF00));

        // R5 bank registers
        access(1, 1, 2'd2, 12'h08, 32'h1234_5678, 16'h0, "R5");
        access(0, 1, 2'd2, 12'h08, 0, 16'h0, "R5");
        check("R5", "secure gmod read", 256'(rd_data), 256'(32'h1234_5678));
        access(0, 0, 2'd2, 12'h08, 0, 16'h0, "R5");
        sec_disable = 1'b1;
        access(1, 1, 2'd2, 12'h0C, 32'hDEAD_BEEF, 16'h0, "R5");
        access(0, 1, 2'd2, 12'h0C, 0, 16'h0, "R5");
        check("R5", "nsacc read with security off", 256'(rd_data), 256'(0));
        sec_disable = 1'b0;

        // R6 priority layout
        access(1, 1, 2'd2, 12'h44, 32'h4433_2211, 16'h0, "R6");
        access(0, 1, 2'd0, 12'h46, 0, 16'h0, "R6");
        check("R6", "byte read lane", 256'(rd_data), 256'(32'h33));
        access(1, 1, 2'd0, 12'h5F, 32'h0000_00C5, 16'h0, "R6");
        check("R6", "top byte", 256'(prio_flat[255:248]), 256'(8'hC5));

        // R7 non-secure priority view
        access(1, 0, 2'd0, 12'h48, 32'h40, 16'h0, "R7");
        check("R7", "ns stored value", 256'(prio_flat[71:64]), 256'(8'hA0));
        access(0, 0, 2'd0, 12'h48, 0, 16'h0, "R7");
        check("R7", "ns read view", 256'(rd_data), 256'(32'h40));
        access(1, 0, 2'd0, 12'h44, 32'h77, 16'h0, "R7");
        check("R7", "ns group0 write ignored", 256'(prio_flat[39:32]), 256'(8'h11));
        access(0, 0, 2'd2, 12'h44, 0, 16'h0, "R7");

        // R9 trigger configuration
        access(1, 1, 2'd2, 12'h2C, 32'h0000_000A, 16'h0, "R9");
        check("R9", "edge bits 16,17", 256'(edge_vec), 256'(32'h0003_FFFF));
        access(1, 1, 2'd2, 12'h28, 32'h0, 16'h0, "R9");
        access(0, 1, 2'd2, 12'h28, 0, 16'h0, "R9");
        check("R9", "cfg0 read-only", 256'(rd_data), 256'(32'hAAAA_AAAA));
        access(0, 1, 2'd2, 12'h2C, 0, 16'h0, "R9");

        // R8 pending view: line 2 (irq 18) level, line 1 (irq 17) edge
        access(0, 1, 2'd2, 12'h18, 0, 16'h0004, "R8");
        check("R8", "level pending", 256'(pending_vec[18]), 256'(1));
        access(0, 1, 2'd2, 12'h18, 0, 16'h0002, "R8");
        access(0, 1, 2'd2, 12'h18, 0, 16'h0000, "R8");
        check("R8", "edge latched after drop", 256'(pending_vec[18:17]), 256'(2'b01));

        // R12 clear-pending write and rising edge on irq 16 same cycle
        access(1, 1, 2'd2, 12'h1C, 32'h0003_0000, 16'h0001, "R12");
        check("R12", "edge wins over clear", 256'(pending_vec[17:16]), 256'(2'b01));

        // R10 wake
        access(1, 1, 2'd2, 12'h00, 32'hFFFF_FFFF, 16'h0001, "R10");
        access(0, 1, 2'd2, 12'h00, 0, 16'h0001, "R10");
        check("R10", "wake read", 256'(rd_data), 256'(32'h3));
        access(1, 0, 2'd2, 12'h00, 32'h0, 16'h0001, "R10");

        // R11 invalid accesses
        access(0, 1, 2'd2, 12'h30, 0, 16'h0001, "R11");
        access(1, 1, 2'd1, 12'h10, 32'hFFFF_FFFF, 16'h0001, "R11");
        access(1, 1, 2'd0, 12'h10, 32'hFF, 16'h0001, "R11");
        access(0, 1, 2'd2, 12'h42, 0, 16'h0001, "R11");
        access(1, 1, 2'd3, 12'h40, 32'hFFFF_FFFF, 16'h0001, "R11");
        acc_valid = 1'b0;
        @(negedge clk);
        check("R11", "error pulse one cycle", 256'(err_pulse), 256'(0));
        m_line = ppi_level;

        // random mix
        lv = ppi_level;
        for (int n = 0; n < 3000; n++) begin
            int r;
            logic [11:0] a;
            logic [1:0]  sz;
            if ($urandom % 16 == 0) sec_disable = $urandom % 2;
            if ($urandom % 4 == 0) lv = 16'($urandom);
            r = $urandom % 21;
            sz = 2'd2;
            if (r < 12) a = 12'(4 * r);
            else if (r < 16) a = 12'h40 + 12'(4 * ($urandom % 8));
            else if (r < 19) begin a = 12'h40 + 12'($urandom % 32); sz = 2'd0; end
            else if (r == 19) a = ($urandom % 2) ? 12'h30 : 12'h100;
            else begin a = 12'(4 * ($urandom % 12)); sz = ($urandom % 2) ? 2'd1 : 2'd3; end
            access($urandom % 2, $urandom % 2, sz, a, $urandom, lv, "R2/R3/R8");
        end
        summary();
    end
endmodule